// File: doc/BRIEF.md
# Printer Port Register Block with Self-Emulated Printer

This block presents the three byte-wide registers of a standard printer port (data, status, control) to a host over a simple synchronous read/write bus. It does not drive real port pins. It models the attached printer itself. When the host raises strobe, the byte held in the output data latch goes out on a byte stream. The printer's busy and acknowledge flags then step forward each time the host polls status. When the host enables it, an interrupt level announces that the printer has acknowledged.

The bus takes at most one access per cycle. If write and read are both asserted, the write wins and the read has no side effect. Read data is combinational from the current register state while the read strobe is high. All side effects of an access take place at the clock edge that ends it. A separate input port lets the surrounding logic load the byte that the host sees when the port is turned around for input.

Top module: `lpt_regblock`

## Requirements
- R1: Only the low 3 address bits are decoded, so any higher bits are ignored. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. A write to offset 1 or to offsets 3 to 7 changes nothing.
- R2: After reset, both data registers hold 0xFF, status reads 0xD9, control reads 0xCC, the interrupt output is low and no byte is emitted.
- R3: A control write stores the written value with bits 7 and 6 forced to 1. A control read returns the stored value.
- R4: A data write stores the byte. A data read returns the input-data register when control bit 5 (direction) is set, and the last written byte otherwise. The input-data register loads from `ext_din` on every cycle in which `ext_load` is high.
- R5: A control write with bit 2 (init) clear sets status to 0xD8.
- R6: A control write with init set, bit 3 (select) set and bit 0 (strobe) set clears status bit 7 (busy-complement). If the previously stored strobe bit was 0, the data byte appears on `tx_data` with `tx_valid` high for exactly one cycle, in the cycle after the write.
- R7: A control write with init and select set and strobe clear sets the interrupt-pending flag, but only when the previously stored control has bit 4 (interrupt enable) set. `irq` follows that flag and goes high in the cycle after the write.
- R8: A status read returns the current status and clears the interrupt-pending flag, so `irq` is low after it. If status bit 7 is 0 and the stored strobe is 0, the read also advances the handshake. When bit 6 (ack) is set, the read clears it. Otherwise the read sets both bit 6 and bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address; only the low 3 bits are decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_din | input | 8 | Byte for the input-data register |
| ext_load | input | 1 | Load enable for the input-data register |
| tx_valid | output | 1 | One-cycle pulse marking an emitted byte |
| tx_data | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The bench builds the block with `ADDR_W` = 8 instead of the default 4. This lets it drive addresses whose upper bits are set, which alias the three registers and the unused offsets. That makes the masking in R1 observable. A reference model inside the bench steps the busy/ack handshake through its full cycle. It covers repeated strobe-high writes that must emit only once, interrupt arming that depends on the previous enable, and the init-clear override of status.

// File: rtl/lpt_pkg.sv
// Package lpt_pkg: shared constants and types for the printer port block.
// Assumes an 8-bit register width and a 3-bit register offset space.
package lpt_pkg;
    localparam int REG_W = 8;
    localparam int OFS_W = 3;
    localparam int NREG  = 3;

    // register offsets that are decoded
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CTRL = 2;

    // status bit positions
    localparam int ST_BUSY_N = 7;
    localparam int ST_ACK    = 6;

    // control bit positions
    localparam int CT_DIR   = 5;
    localparam int CT_IRQEN = 4;
    localparam int CT_SEL   = 3;
    localparam int CT_INIT  = 2;
    localparam int CT_STB   = 0;

    localparam logic [REG_W-1:0] RST_DATA    = 8'hFF;
    localparam logic [REG_W-1:0] RST_STATUS  = 8'hD9;
    localparam logic [REG_W-1:0] RST_CTRL    = 8'hCC;
    localparam logic [REG_W-1:0] CTRL_FORCE  = 8'hC0;
    localparam logic [REG_W-1:0] INIT_STATUS = 8'hD8;
    localparam logic [REG_W-1:0] IDLE_READ   = 8'hFF;

    // decoded accesses for one cycle
    typedef struct packed {
        logic wr_data;
        logic wr_ctrl;
        logic rd_stat;
    } lpt_acc_t;

    // events raised by a control write
    typedef struct packed {
        logic init_clr;
        logic stb_hi;
        logic arm_irq;
    } lpt_ev_t;
endpackage

// File: rtl/lpt_decode.sv
// Module lpt_decode: turns the bus strobes and address into per-register
// access pulses. Assumes ADDR_W >= OFS_W; upper address bits are ignored.
// A write in the same cycle as a read suppresses the read.
module lpt_decode
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output lpt_acc_t          acc,
    output logic [OFS_W-1:0]  ofs
);
    logic [NREG-1:0] sel;

    assign ofs = bus_addr[OFS_W-1:0];

    // one select line per decoded register
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i] = (ofs == OFS_W'(i));
    end

    // upper address bits are aliased away
    if (ADDR_W > OFS_W) begin : g_hi
        logic addr_hi_unused;
        assign addr_hi_unused = ^bus_addr[ADDR_W-1:OFS_W];
    end

    // access pulses, write has priority over read
    always_comb begin
        acc.wr_data = bus_wr & sel[OFS_DATA];
        acc.wr_ctrl = bus_wr & sel[OFS_CTRL];
        acc.rd_stat = bus_rd & ~bus_wr & sel[OFS_STAT];
    end
endmodule

// File: rtl/lpt_ctrl_path.sv
// Module lpt_ctrl_path: holds the control register and both data
// registers, classifies control writes into handshake events, and emits
// the output byte on a strobe rising edge. Assumes decoded access pulses.
module lpt_ctrl_path
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lpt_acc_t         acc,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [REG_W-1:0] ext_din,
    input  logic             ext_load,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] dataw_q,
    output logic [REG_W-1:0] datar_q,
    output lpt_ev_t          ev,
    output logic             tx_valid,
    output logic [REG_W-1:0] tx_data
);
    logic [REG_W-1:0] ctrl_new;
    logic             sel_ok;

    // candidate control value and event classification
    always_comb begin
        ctrl_new    = bus_wdata | CTRL_FORCE;
        sel_ok      = acc.wr_ctrl & ctrl_new[CT_INIT] & ctrl_new[CT_SEL];
        ev.init_clr = acc.wr_ctrl & ~ctrl_new[CT_INIT];
        ev.stb_hi   = sel_ok & ctrl_new[CT_STB];
        ev.arm_irq  = sel_ok & ~ctrl_new[CT_STB] & ctrl_q[CT_IRQEN];
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)           ctrl_q <= RST_CTRL;
        else if (acc.wr_ctrl) ctrl_q <= ctrl_new;
    end

    // output data latch
    always_ff @(posedge clk) begin
        if (!rst_n)           dataw_q <= RST_DATA;
        else if (acc.wr_data) dataw_q <= bus_wdata;
    end

    // input data register
    always_ff @(posedge clk) begin
        if (!rst_n)        datar_q <= RST_DATA;
        else if (ext_load) datar_q <= ext_din;
    end

    // byte emission on a strobe rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= ev.stb_hi & ~ctrl_q[CT_STB];
            if (ev.stb_hi & ~ctrl_q[CT_STB]) tx_data <= dataw_q;
        end
    end
endmodule

// File: rtl/lpt_status_hs.sv
// Module lpt_status_hs: status register with the self-emulated printer
// handshake, plus the interrupt-pending flag. Assumes events from
// lpt_ctrl_path and a status-read pulse from lpt_decode.
module lpt_status_hs
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lpt_acc_t         acc,
    input  lpt_ev_t          ev,
    input  logic             stb_q,
    output logic [REG_W-1:0] status_q,
    output logic             irq_q
);
    logic hs_step;

    // handshake may advance only while not busy and strobe low
    assign hs_step = acc.rd_stat & ~status_q[ST_BUSY_N] & ~stb_q;

    // status register and handshake sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RST_STATUS;
        end else if (ev.init_clr) begin
            status_q <= INIT_STATUS;
        end else if (ev.stb_hi) begin
            status_q[ST_BUSY_N] <= 1'b0;
        end else if (hs_step) begin
            if (status_q[ST_ACK]) begin
                status_q[ST_ACK] <= 1'b0;
            end else begin
                status_q[ST_ACK]    <= 1'b1;
                status_q[ST_BUSY_N] <= 1'b1;
            end
        end
    end

    // interrupt-pending flag, which drives the interrupt output
    always_ff @(posedge clk) begin
        if (!rst_n)           irq_q <= 1'b0;
        else if (ev.arm_irq)  irq_q <= 1'b1;
        else if (acc.rd_stat) irq_q <= 1'b0;
    end
endmodule

// File: rtl/lpt_regblock.sv
// Module lpt_regblock: top of the printer port register block. Ties the
// decoder, control/data path and status handshake together and muxes
// read data. Assumes one bus access per cycle; read data is combinational.
module lpt_regblock
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        ext_din,
    input  logic              ext_load,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    lpt_acc_t         acc;
    lpt_ev_t          ev;
    logic [OFS_W-1:0] ofs;
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] dataw_q;
    logic [REG_W-1:0] datar_q;
    logic [REG_W-1:0] status_q;

    lpt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .acc      (acc),
        .ofs      (ofs)
    );

    lpt_ctrl_path u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .bus_wdata (bus_wdata),
        .ext_din   (ext_din),
        .ext_load  (ext_load),
        .ctrl_q    (ctrl_q),
        .dataw_q   (dataw_q),
        .datar_q   (datar_q),
        .ev        (ev),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    lpt_status_hs u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .ev       (ev),
        .stb_q    (ctrl_q[CT_STB]),
        .status_q (status_q),
        .irq_q    (irq)
    );

    // read data mux by offset
    always_comb begin
        case (ofs)
            OFS_W'(OFS_DATA): bus_rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
            OFS_W'(OFS_STAT): bus_rdata = status_q;
            OFS_W'(OFS_CTRL): bus_rdata = ctrl_q;
            default:          bus_rdata = IDLE_READ;
        endcase
    end
endmodule

// File: rtl/lpt_regblock_chk.sv
// Module lpt_regblock_chk: property checks on the printer port block,
// attached by bind. Assumes it observes the top ports and status_q.
module lpt_regblock_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              tx_valid,
    input logic              irq,
    input logic [7:0]        status_q
);
    // R1
    unused_ofs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[2:0] > 3'd2) |-> (bus_rdata == 8'hFF));

    // R3
    ctrl_top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[2:0] == 3'd2) |-> (bus_rdata[7:6] == 2'b11));

    // R5
    init_clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[2:0] == 3'd2 && !bus_wdata[2]) |=> (status_q == 8'hD8));

    // R6
    tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_wr && bus_addr[2:0] == 3'd2));

    // R8
    irq_clear_on_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr[2:0] == 3'd1) |=> !irq);
endmodule

bind lpt_regblock lpt_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .irq       (irq),
    .status_q  (status_q)
);

// File: tb/sim_lpt_regblock.sv
// Bench sim_lpt_regblock: scoreboard bench. Driver tasks update a
// reference model and queue expected reads and bytes; a monitor pops and
// compares them as the design produces results.
module sim_lpt_regblock;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [7:0]    ext_din = '0;
    logic          ext_load = 1'b0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          irq;

    always #5 clk = ~clk;

    lpt_regblock #(.ADDR_W(AW)) u0 (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .ext_din (ext_din), .ext_load (ext_load), .tx_valid (tx_valid),
        .tx_data (tx_data), .irq (irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] rd_exp_q[$];
    string      rd_tag_q[$];
    logic [7:0] tx_exp_q[$];
    string      tx_tag_q[$];

    // reference model state
    logic [7:0] m_dataw, m_datar, m_status, m_ctrl;
    logic       m_irq;

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] v;
        case (a[2:0])
            3'd0: m_dataw = d;
            3'd2: begin
                v = d | 8'hC0;
                if (!v[2]) m_status = 8'hD8;
                else if (v[3]) begin
                    if (v[0]) begin
                        m_status[7] = 1'b0;
                        if (!m_ctrl[0]) begin
                            tx_exp_q.push_back(m_dataw);
                            tx_tag_q.push_back("R6 emitted byte");
                        end
                    end else if (m_ctrl[4]) m_irq = 1'b1;
                end
                m_ctrl = v;
            end
            default: ;
        endcase
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [7:0] e;
        case (a[2:0])
            3'd0: e = m_ctrl[5] ? m_datar : m_dataw;
            3'd1: begin
                e = m_status;
                m_irq = 1'b0;
                if (!m_status[7] && !m_ctrl[0]) begin
                    if (m_status[6]) m_status[6] = 1'b0;
                    else m_status[7:6] = 2'b11;
                end
            end
            3'd2: e = m_ctrl;
            default: e = 8'hFF;
        endcase
        rd_exp_q.push_back(e);
        rd_tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic load(input logic [7:0] d);
        m_datar = d; ext_din = d; ext_load = 1'b1;
        cyc();
        ext_load = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        check8(tag, {7'b0, irq}, {7'b0, m_irq});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: compare reads and emitted bytes against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bus_rd && !bus_wr) begin
                if (rd_exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R1 unexpected read actual=%02h expected=none", bus_rdata);
                end else begin
                    check8(rd_tag_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
                end
            end
            if (tx_valid) begin
                if (tx_exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R6 unexpected byte actual=%02h expected=none", tx_data);
                end else begin
                    check8(tx_tag_q.pop_front(), tx_data, tx_exp_q.pop_front());
                end
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    // stimulus
    initial begin
        m_dataw = 8'hFF; m_datar = 8'hFF; m_status = 8'hD9; m_ctrl = 8'hCC; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R2 reset state
        chk_irq("R2 irq after reset");
        check8("R2 no byte after reset", {7'b0, tx_valid}, 8'h00);
        rd(8'h02, "R2 control reset");
        rd(8'h01, "R2 status reset");
        rd(8'h00, "R2 data reset");
        // R1 unused offsets and aliasing
        for (int i = 3; i < 8; i++) rd(8'(i), "R1 unused offset reads FF");
        rd(8'hA2, "R1 aliased control read");
        wr(8'h01, 8'h00);
        wr(8'h05, 8'h12);
        rd(8'hF9, "R1 status write ignored");
        // R4 data path in both directions
        wr(8'h00, 8'h5A);
        rd(8'h00, "R4 written byte readback");
        load(8'h3C);
        wr(8'h02, 8'h2C);
        rd(8'h00, "R4 input register with direction set");
        rd(8'h02, "R3 control forced bits");
        // R6 strobe edge and handshake R8
        wr(8'h02, 8'h0D);
        rd(8'h01, "R6 busy cleared");
        wr(8'h02, 8'h0C);
        chk_irq("R7 no irq without enable");
        rd(8'h01, "R8 ack clears");
        rd(8'h01, "R8 ack and busy set");
        rd(8'h01, "R8 no further change");
        // R6 repeated strobe high emits once
        wr(8'h00, 8'hA7);
        wr(8'h02, 8'h0D);
        wr(8'h02, 8'h0D);
        wr(8'h02, 8'h0C);
        // R7 interrupt needs previous enable
        wr(8'h02, 8'h1C);
        chk_irq("R7 enable in same write does not arm");
        wr(8'h02, 8'h1C);
        chk_irq("R7 irq raised");
        rd(8'h02, "R3 control with enable");
        chk_irq("R7 control read keeps irq");
        rd(8'h01, "R8 status read value");
        chk_irq("R8 irq cleared by status read");
        // R5 init clear
        wr(8'h02, 8'h08);
        rd(8'h01, "R5 status after init clear");
        // select clear: no handshake effect
        wr(8'h02, 8'h05);
        rd(8'h01, "R6 no effect without select");
        rd(8'h02, "R3 control value 05");
        repeat (4) cyc();
        check8("R6 all expected bytes emitted", 8'(tx_exp_q.size()), 8'h00);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule